// File: doc/BRIEF.md
# Multi-Level Interrupt Priority Arbiter

This block sits between the interrupt sources of a small microcontroller and its CPU sequencer. It takes two kinds of request: active-low external pins, each of which can be set to level or falling-edge sensing, and plain request lines from on-chip peripherals. Each request is gated by its own enable bit and by one global enable. The block then picks one winner and presents its vector address to the CPU through a request/acknowledge handshake.

Each source has a two-bit priority level. The high bit comes from a high-priority register bit and the low bit from the matching low-priority register bit, which gives four levels. When several pending sources share the highest level, the lowest source index wins. An in-service bit for each level records nesting. A new request is offered only when its level is strictly above the highest level now in service. It is also offered only when the CPU reports an instruction boundary, and only when that instruction is neither a return-from-interrupt nor a write to the enable or priority registers. A return-complete strobe from the CPU releases the highest active level.

Top module: `irq_prio_arbiter`

## Requirements
- R1: While `rst_n` is low and in the first cycle after reset, `vec_req` is 0 and no level is in service.
- R2: A source is offered only when its bit in `src_en` and `global_en` are both 1; clearing either one suppresses it.
- R3: The level of source i is `{prio_hi[i], prio_lo[i]}` (0 lowest, 3 highest), and a higher level wins regardless of source index.
- R4: Among pending sources at the same level, the lowest index wins (index 0 first).
- R5: `vec_req` rises only on the clock edge after a cycle in which `instr_end` was 1.
- R6: `vec_req` does not rise after a cycle in which `reti_busy` or `irq_reg_write` was 1.
- R7: `vec_addr` is 0x0003 + 8*index of the offered source, and it stays unchanged while `vec_req` is high and not acknowledged.
- R8: A source is offered only when its level is strictly higher than the highest level in service, so an equal or lower level waits.
- R9: A `reti_done` pulse clears the in-service bit of the highest active level, and sources at or below the remaining highest in-service level stay blocked.
- R10: Sources 0 and 1 are external active-low pins. With `ext_edge_sel[j]`=0 the pin requests while it is low. With `ext_edge_sel[j]`=1 a high sample followed by a low sample sets a flag that holds after the pin returns high, and a pin held low does not set it again.
- R11: An edge flag is cleared when its vector is acknowledged. A level-sensed pin is not latched, so a low pulse that is never offered leaves no request behind.
- R12: Once raised, `vec_req` stays high until `vec_ack`, and it falls on the edge where `vec_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_pin_n | input | NUM_EXT | Active-low external request pins (sources 0..NUM_EXT-1) |
| ext_edge_sel | input | NUM_EXT | 1: falling-edge sensing, 0: level sensing, one bit per pin |
| periph_req | input | NUM_SRC-NUM_EXT | Peripheral request lines (sources NUM_EXT upward) |
| src_en | input | NUM_SRC | Enable bit for each source |
| global_en | input | 1 | Global enable, 0 masks every source |
| prio_lo | input | NUM_SRC | Low bit of each source's level |
| prio_hi | input | NUM_SRC | High bit of each source's level |
| instr_end | input | 1 | CPU is at the last cycle of an instruction |
| reti_busy | input | 1 | Current instruction is a return-from-interrupt |
| irq_reg_write | input | 1 | Current instruction writes an enable or priority register |
| reti_done | input | 1 | One-cycle strobe: return-from-interrupt completed |
| vec_ack | input | 1 | CPU accepts the offered vector |
| vec_req | output | 1 | Vector request to the CPU |
| vec_addr | output | ADDR_W | Vector address of the offered source |

## Verification
The bench arranges pending sets that separate the two ordering rules. Two sources at the same level show the polling order. A high-index source at a higher level shows that level beats index. A level-1 source against a level-2 source shows which priority bit carries more weight. Nesting is tried with a same-level source, a lower-level source and a higher-level source while one level is in service, and then with successive return strobes, so that a design clearing the wrong level or comparing with "greater or equal" offers the wrong vector. The external pins are tried as held-low and pulsed-low in both sensing modes, which tells a latched edge apart from a level that is not latched.

// File: rtl/irq_arb_pkg.sv
// Package: shared level type and helpers for the interrupt priority arbiter.
// Assumes exactly two priority register bits per source, hence four levels.
package irq_arb_pkg;
    localparam int LVL_W   = 2;
    localparam int NUM_LVL = 1 << LVL_W;
    localparam int RANK_W  = LVL_W + 1;   // 0 = nothing in service, 1..NUM_LVL = level+1

    typedef logic [LVL_W-1:0]  lvl_t;
    typedef logic [RANK_W-1:0] rank_t;

    // Combine the two priority register bits into a level (high bit is weightier).
    function automatic lvl_t make_level(input logic hi, input logic lo);
        return {hi, lo};
    endfunction
endpackage

// File: rtl/irq_ext_capture.sv
// Module: irq_ext_capture
// Samples active-low external pins and produces one request per pin.
// Level mode: request while the sampled pin is low.
// Edge mode: a high sample followed by a low sample sets a flag that is held
// until the matching clear pulse (vector acknowledge); a set wins over a clear.
// Assumes the pins are already synchronous to clk.
module irq_ext_capture #(
    parameter int NUM_EXT = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EXT-1:0] pin_n,
    input  logic [NUM_EXT-1:0] edge_sel,
    input  logic [NUM_EXT-1:0] clr,
    output logic [NUM_EXT-1:0] req
);
    for (genvar j = 0; j < NUM_EXT; j++) begin : g_line
        logic smp_now;
        logic smp_prev;
        logic flag;
        logic fall;

        // Sample the pin and keep the previous sample for edge detection.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                smp_now  <= 1'b1;
                smp_prev <= 1'b1;
            end else begin
                smp_now  <= pin_n[j];
                smp_prev <= smp_now;
            end
        end

        assign fall = smp_prev & ~smp_now;

        // Hold the edge flag until the acknowledge clears it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flag <= 1'b0;
            else if (edge_sel[j] && fall)
                flag <= 1'b1;
            else if (clr[j] || !edge_sel[j])
                flag <= 1'b0;
        end

        // Pick the request for the selected sensing mode.
        always_comb begin
            req[j] = edge_sel[j] ? flag : ~smp_now;
        end
    end
endmodule

// File: rtl/irq_prio_resolver.sv
// Module: irq_prio_resolver
// Combinational winner selection: the highest level among pending sources,
// and the lowest index among those at that level.
// Assumes pend is already gated by the enables.
module irq_prio_resolver
    import irq_arb_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] pend,
    input  logic [NUM_SRC-1:0] prio_hi,
    input  logic [NUM_SRC-1:0] prio_lo,
    output logic               found,
    output logic [IDX_W-1:0]   win_idx,
    output lvl_t               win_lvl
);
    // Scan upward; only a strictly higher level displaces an earlier winner.
    always_comb begin
        found   = 1'b0;
        win_idx = '0;
        win_lvl = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (pend[i] && (!found || make_level(prio_hi[i], prio_lo[i]) > win_lvl)) begin
                found   = 1'b1;
                win_idx = IDX_W'(i);
                win_lvl = make_level(prio_hi[i], prio_lo[i]);
            end
        end
    end
endmodule

// File: rtl/irq_nest_tracker.sv
// Module: irq_nest_tracker
// One in-service bit per level. An acknowledge sets the bit of the served
// level; a return strobe clears the highest set bit. Reports the highest
// active level as a rank (0 when nothing is in service).
// Assumes a set and a clear in the same cycle are both applied.
module irq_nest_tracker
    import irq_arb_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  set_en,
    input  lvl_t  set_lvl,
    input  logic  clr_en,
    output rank_t rank
);
    logic [NUM_LVL-1:0] isv;
    logic [NUM_LVL-1:0] top_mask;
    logic [NUM_LVL-1:0] set_mask;

    // Find the highest in-service level and its one-hot mask.
    always_comb begin
        rank     = '0;
        top_mask = '0;
        for (int l = 0; l < NUM_LVL; l++) begin
            if (isv[l]) begin
                rank     = RANK_W'(l + 1);
                top_mask = '0;
                top_mask[l] = 1'b1;
            end
        end
    end

    // Decode the level being entered.
    always_comb begin
        set_mask = '0;
        if (set_en)
            set_mask[set_lvl] = 1'b1;
    end

    // Update the in-service bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            isv <= '0;
        else
            isv <= (clr_en ? (isv & ~top_mask) : isv) | set_mask;
    end
endmodule

// File: rtl/irq_prio_arbiter.sv
// Module: irq_prio_arbiter (top)
// Gates requests by enables, resolves the winner, checks it against the
// nesting state and the CPU blocking conditions, and offers its vector
// through a request/acknowledge handshake. The offered vector is latched
// and held until acknowledged.
// Assumes external sources occupy indices 0..NUM_EXT-1 and peripheral
// sources the indices above them.
module irq_prio_arbiter
    import irq_arb_pkg::*;
#(
    parameter int              NUM_SRC    = 8,
    parameter int              NUM_EXT    = 2,
    parameter int              ADDR_W     = 16,
    parameter logic [15:0]     VEC_BASE   = 16'h0003,
    parameter int              VEC_STRIDE = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_EXT-1:0]         ext_pin_n,
    input  logic [NUM_EXT-1:0]         ext_edge_sel,
    input  logic [NUM_SRC-NUM_EXT-1:0] periph_req,
    input  logic [NUM_SRC-1:0]         src_en,
    input  logic                       global_en,
    input  logic [NUM_SRC-1:0]         prio_lo,
    input  logic [NUM_SRC-1:0]         prio_hi,
    input  logic                       instr_end,
    input  logic                       reti_busy,
    input  logic                       irq_reg_write,
    input  logic                       reti_done,
    input  logic                       vec_ack,
    output logic                       vec_req,
    output logic [ADDR_W-1:0]          vec_addr
);
    localparam int IDX_W = $clog2(NUM_SRC);

    logic [NUM_EXT-1:0] ext_req;
    logic [NUM_EXT-1:0] ext_clr;
    logic [NUM_SRC-1:0] raw_req;
    logic [NUM_SRC-1:0] pend;
    logic               found;
    logic [IDX_W-1:0]   win_idx;
    lvl_t               win_lvl;
    rank_t              win_rank;
    rank_t              cur_rank;
    logic               allow;
    logic               take;
    logic               ack_fire;
    logic [IDX_W-1:0]   vec_idx;
    lvl_t               vec_lvl;

    irq_ext_capture #(.NUM_EXT(NUM_EXT)) ext_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_n    (ext_pin_n),
        .edge_sel (ext_edge_sel),
        .clr      (ext_clr),
        .req      (ext_req)
    );

    // Merge source requests and apply the individual and global enables.
    always_comb begin
        raw_req = {periph_req, ext_req};
        pend    = raw_req & src_en & {NUM_SRC{global_en}};
    end

    irq_prio_resolver #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) res_i (
        .pend    (pend),
        .prio_hi (prio_hi),
        .prio_lo (prio_lo),
        .found   (found),
        .win_idx (win_idx),
        .win_lvl (win_lvl)
    );

    irq_nest_tracker nest_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (ack_fire),
        .set_lvl (vec_lvl),
        .clr_en  (reti_done),
        .rank    (cur_rank)
    );

    // Decide whether a new vector may be offered this cycle.
    always_comb begin
        win_rank = RANK_W'(win_lvl) + RANK_W'(1);
        allow    = instr_end & ~reti_busy & ~irq_reg_write;
        take     = ~vec_req & found & allow & (win_rank > cur_rank);
        ack_fire = vec_req & vec_ack;
    end

    // Clear the edge flag of the source whose vector was acknowledged.
    for (genvar j = 0; j < NUM_EXT; j++) begin : g_clr
        assign ext_clr[j] = ack_fire && (vec_idx == IDX_W'(j));
    end

    // Handshake register: latch the winner and hold it until acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_req <= 1'b0;
            vec_idx <= '0;
            vec_lvl <= '0;
        end else if (ack_fire) begin
            vec_req <= 1'b0;
        end else if (take) begin
            vec_req <= 1'b1;
            vec_idx <= win_idx;
            vec_lvl <= win_lvl;
        end
    end

    // Form the vector address from the latched index.
    assign vec_addr = ADDR_W'(VEC_BASE) + ADDR_W'(vec_idx) * ADDR_W'(VEC_STRIDE);
endmodule

// File: rtl/irq_prio_arbiter_chk.sv
// Module: irq_prio_arbiter_chk
// Port-level temporal checks on the arbiter's handshake; bound to the top.
module irq_prio_arbiter_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              vec_req,
    input logic              vec_ack,
    input logic [ADDR_W-1:0] vec_addr,
    input logic              instr_end,
    input logic              reti_busy,
    input logic              irq_reg_write,
    input logic              global_en
);
    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !vec_req); // R1

    AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_req) |-> $past(global_en)); // R2

    AST_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_req) |-> $past(instr_end)); // R5

    AST_NOT_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_req) |-> (!$past(reti_busy) && !$past(irq_reg_write))); // R6

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_req && !vec_ack) |=> $stable(vec_addr)); // R7

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_req && !vec_ack) |=> vec_req); // R12

    AST_REQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_req && vec_ack) |=> !vec_req); // R12
endmodule

bind irq_prio_arbiter irq_prio_arbiter_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .vec_req       (vec_req),
    .vec_ack       (vec_ack),
    .vec_addr      (vec_addr),
    .instr_end     (instr_end),
    .reti_busy     (reti_busy),
    .irq_reg_write (irq_reg_write),
    .global_en     (global_en)
);

// File: tb/irq_prio_arbiter_tb_top.sv
`timescale 1ns/1ps
// Directed bench for irq_prio_arbiter: one task per scenario.
module irq_prio_arbiter_tb_top;
    localparam int NUM_SRC = 8;
    localparam int NUM_EXT = 2;

    logic                       clk = 1'b0;
    logic                       rst_n;
    logic [NUM_EXT-1:0]         ext_pin_n;
    logic [NUM_EXT-1:0]         ext_edge_sel;
    logic [NUM_SRC-NUM_EXT-1:0] periph_req;
    logic [NUM_SRC-1:0]         src_en;
    logic                       global_en;
    logic [NUM_SRC-1:0]         prio_lo;
    logic [NUM_SRC-1:0]         prio_hi;
    logic                       instr_end;
    logic                       reti_busy;
    logic                       irq_reg_write;
    logic                       reti_done;
    logic                       vec_ack;
    logic                       vec_req;
    logic [15:0]                vec_addr;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    irq_prio_arbiter dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .ext_pin_n     (ext_pin_n),
        .ext_edge_sel  (ext_edge_sel),
        .periph_req    (periph_req),
        .src_en        (src_en),
        .global_en     (global_en),
        .prio_lo       (prio_lo),
        .prio_hi       (prio_hi),
        .instr_end     (instr_end),
        .reti_busy     (reti_busy),
        .irq_reg_write (irq_reg_write),
        .reti_done     (reti_done),
        .vec_ack       (vec_ack),
        .vec_req       (vec_req),
        .vec_addr      (vec_addr)
    );

    function automatic logic [31:0] exp_addr(input int idx);
        return 32'(3 + 8 * idx);
    endfunction

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic set_lvl(input int idx, input logic [1:0] lvl);
        prio_hi[idx] = lvl[1];
        prio_lo[idx] = lvl[0];
    endtask

    task automatic preq(input int idx, input logic v);
        periph_req[idx - NUM_EXT] = v;
    endtask

    task automatic service();
        vec_ack = 1'b1;
        tick();
        vec_ack = 1'b0;
    endtask

    task automatic reti();
        reti_done = 1'b1;
        tick();
        reti_done = 1'b0;
    endtask

    task automatic cleanup();
        periph_req   = '0;
        ext_pin_n    = '1;
        ext_edge_sel = '0;
        prio_lo      = '0;
        prio_hi      = '0;
        src_en       = '1;
        global_en    = 1'b1;
        instr_end    = 1'b1;
        reti_busy    = 1'b0;
        irq_reg_write = 1'b0;
        repeat (4) reti();
        tick(3);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        vec_ack = 1'b0;
        reti_done = 1'b0;
        cleanup();
        preq(4, 1'b1);
        tick(2);
        chk("R1 vec_req in reset", 32'(vec_req), 0);
        preq(4, 1'b0);
        rst_n = 1'b1;
        tick();
        chk("R1 vec_req after reset", 32'(vec_req), 0);
    endtask

    task automatic t_enable();
        preq(3, 1'b1);
        src_en[3] = 1'b0;
        tick(3);
        chk("R2 source enable off", 32'(vec_req), 0);
        src_en[3] = 1'b1;
        global_en = 1'b0;
        tick(3);
        chk("R2 global enable off", 32'(vec_req), 0);
        global_en = 1'b1;
        tick(2);
        chk("R2 enabled request", 32'(vec_req), 1);
        chk("R7 address idx3", 32'(vec_addr), exp_addr(3));
        service();
        chk("R12 drop on ack", 32'(vec_req), 0);
        cleanup();
    endtask

    task automatic t_poll();
        preq(5, 1'b1);
        preq(2, 1'b1);
        tick(2);
        chk("R4 idx2 over idx5", 32'(vec_addr), exp_addr(2));
        service();
        cleanup();
        preq(7, 1'b1);
        preq(4, 1'b1);
        tick(2);
        chk("R4 idx4 over idx7", 32'(vec_addr), exp_addr(4));
        service();
        cleanup();
    endtask

    task automatic t_level();
        set_lvl(7, 2'd3);
        preq(2, 1'b1);
        preq(7, 1'b1);
        tick(2);
        chk("R3 level3 idx7 over level0 idx2", 32'(vec_addr), exp_addr(7));
        service();
        cleanup();
        set_lvl(6, 2'd1);
        set_lvl(5, 2'd2);
        preq(6, 1'b1);
        preq(5, 1'b1);
        tick(2);
        chk("R3 high bit outweighs low bit", 32'(vec_addr), exp_addr(5));
        service();
        cleanup();
    endtask

    task automatic t_boundary();
        instr_end = 1'b0;
        preq(3, 1'b1);
        tick(3);
        chk("R5 no request mid-instruction", 32'(vec_req), 0);
        instr_end = 1'b1;
        tick();
        chk("R5 request at boundary", 32'(vec_req), 1);
        service();
        cleanup();
    endtask

    task automatic t_block();
        reti_busy = 1'b1;
        preq(6, 1'b1);
        tick(3);
        chk("R6 blocked by return", 32'(vec_req), 0);
        reti_busy = 1'b0;
        irq_reg_write = 1'b1;
        tick(3);
        chk("R6 blocked by register write", 32'(vec_req), 0);
        irq_reg_write = 1'b0;
        tick();
        chk("R6 released", 32'(vec_req), 1);
        chk("R7 address idx6", 32'(vec_addr), exp_addr(6));
        service();
        cleanup();
    endtask

    task automatic t_hold();
        preq(3, 1'b1);
        tick(2);
        chk("R12 request raised", 32'(vec_req), 1);
        preq(3, 1'b0);
        set_lvl(7, 2'd3);
        preq(7, 1'b1);
        tick(3);
        chk("R12 request held", 32'(vec_req), 1);
        chk("R7 address held", 32'(vec_addr), exp_addr(3));
        service();
        tick();
        chk("R8 higher level preempts", 32'(vec_req), 1);
        chk("R8 preempting address", 32'(vec_addr), exp_addr(7));
        service();
        cleanup();
    endtask

    task automatic t_nest();
        set_lvl(2, 2'd1);
        set_lvl(3, 2'd1);
        set_lvl(5, 2'd2);
        preq(2, 1'b1);
        tick(2);
        chk("R8 first level1 offered", 32'(vec_addr), exp_addr(2));
        service();
        preq(2, 1'b0);
        preq(3, 1'b1);
        preq(4, 1'b1);
        tick(3);
        chk("R8 same and lower level wait", 32'(vec_req), 0);
        preq(5, 1'b1);
        tick(2);
        chk("R8 level2 preempts level1", 32'(vec_req), 1);
        chk("R8 level2 address", 32'(vec_addr), exp_addr(5));
        service();
        preq(5, 1'b0);
        tick(2);
        chk("R8 nothing above level2", 32'(vec_req), 0);
        reti();
        tick(2);
        chk("R9 level1 still in service", 32'(vec_req), 0);
        reti();
        tick(2);
        chk("R9 released after second return", 32'(vec_req), 1);
        chk("R9 level1 idx3 wins over idx4", 32'(vec_addr), exp_addr(3));
        service();
        cleanup();
    endtask

    task automatic t_ext_level();
        ext_pin_n[0] = 1'b0;
        tick(2);
        chk("R10 level pin request", 32'(vec_req), 1);
        chk("R10 level pin address", 32'(vec_addr), exp_addr(0));
        service();
        ext_pin_n[0] = 1'b1;
        cleanup();
        instr_end = 1'b0;
        ext_pin_n[0] = 1'b0;
        tick(2);
        ext_pin_n[0] = 1'b1;
        tick(2);
        instr_end = 1'b1;
        tick(2);
        chk("R11 level pulse not latched", 32'(vec_req), 0);
        cleanup();
    endtask

    task automatic t_ext_edge();
        ext_edge_sel[1] = 1'b1;
        tick();
        ext_pin_n[1] = 1'b0;
        tick();
        ext_pin_n[1] = 1'b1;
        tick(3);
        chk("R10 edge latched after pin returns", 32'(vec_req), 1);
        chk("R10 edge address", 32'(vec_addr), exp_addr(1));
        service();
        reti();
        tick(3);
        chk("R11 edge flag cleared by ack", 32'(vec_req), 0);
        ext_pin_n[1] = 1'b0;
        tick(4);
        chk("R10 held-low edge request", 32'(vec_req), 1);
        service();
        reti();
        tick(3);
        chk("R10 held low does not retrigger", 32'(vec_req), 0);
        ext_pin_n[1] = 1'b1;
        cleanup();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_enable();
        t_poll();
        t_level();
        t_boundary();
        t_block();
        t_hold();
        t_nest();
        t_ext_level();
        t_ext_edge();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule